// File: doc/BRIEF.md
# Two-Lane Block Splitter with Alignment Markers

This block takes a single stream of scrambled 66-bit blocks belonging to one 10G signal and deals the blocks, one whole block at a time, alternately onto two sub-lanes. The two sub-lane outputs then join the sub-lanes of other signal instances, with twenty sub-lanes in total, ahead of a bit multiplexer.

On a shared timing strobe, both sub-lanes emit an alignment marker block in the same cycle. A common timing source drives the strobe of every instance, which keeps the markers in lockstep across all instances. Normally that source pulses once every 16384 sub-lane slots, so each sub-lane carries 16383 data blocks between markers. Each marker carries a fixed three-byte identifier for its sub-lane, chosen by the signal index parameter and the sub-lane number. It also carries a parity byte and its inverse. The parity byte is computed over everything that sub-lane sent since its previous marker, that marker included.

While a marker is being emitted, the block holds the input off for that one slot, so no data block is lost. Making room for the markers in the stream's rate is left to the logic upstream.

Top module: `mlg_pair_splitter`

## Requirements
- R1: After reset, both sub-lane valid outputs are low. When `mark_now` is low, `in_ready` is high.
- R2: A block is accepted in a cycle where `in_valid` and `in_ready` are both high. The block appears unchanged on one sub-lane one cycle later, with that sub-lane's valid high and the other's low. The first block accepted after reset goes to sub-lane 0, and later accepted blocks alternate 1, 0, 1, and so on.
- R3: Marker cycles and idle cycles do not change the alternation. The next accepted block goes to the sub-lane that follows the last data block's sub-lane.
- R4: In a cycle with `mark_now` high, `in_ready` is low and no block is accepted. In the next cycle, both valid outputs are high and both sub-lanes carry a marker. A block held at the input during the marker cycle is delivered later, unchanged.
- R5: Marker layout, with bit 0 sent first: bits [1:0] = 2'b10 (not scrambled). The payload bytes are M0 = [9:2], M1 = [17:10], M2 = [25:18], P = [33:26], M4 = [41:34], M5 = [49:42], M6 = [57:50], Q = [65:58]. M4, M5 and M6 are the bitwise inverses of M0, M1 and M2.
- R6: For signal index 0, sub-lane 0 uses M0..M2 = 0x80, 0xB4, 0xAF and sub-lane 1 uses 0x29, 0x85, 0x1D. Other indices use their own fixed entries from the same table.
- R7: Parity byte P: bit i is the XOR, over every block in the window, of bit i of each of the eight payload bytes (byte k is bits [2+8k+7 : 2+8k]). In addition, block bit 0 is folded into P bit 3 and block bit 1 into P bit 4.
- R8: Byte Q of every marker equals the bitwise inverse of P.
- R9: A sub-lane's parity window runs from its previous marker, that marker included, up to the current marker, which is excluded. Before the first marker, the window starts at reset and begins empty (parity 0).
- R10: In a cycle with neither an accepted block nor `mark_now`, both valid outputs are low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_blk | input | 66 | Incoming scrambled block, bits [1:0] sync header |
| in_valid | input | 1 | Incoming block present |
| in_ready | output | 1 | Block can be accepted this cycle |
| mark_now | input | 1 | Shared strobe: emit markers on both sub-lanes next cycle |
| lane0_blk | output | 66 | Sub-lane 0 block |
| lane0_vld | output | 1 | Sub-lane 0 block valid |
| lane1_blk | output | 66 | Sub-lane 1 block |
| lane1_vld | output | 1 | Sub-lane 1 block valid |

## Verification
A wrong lane-select state shows up one cycle after the next accepted block: the block lands on the wrong sub-lane, and every later block stays wrong until reset. A corrupted or mis-cleared parity accumulator does not show until the next marker. There, the P and Q bytes of that sub-lane differ from the parity computed in the bench. Because the accumulator restarts from each marker, the bench uses windows from zero to several blocks long, including back-to-back markers.

// File: rtl/mlg_split_pkg.sv
package mlg_split_pkg;
  localparam int BLK_W   = 66;
  localparam int BYTE_W  = 8;
  localparam int PAY_BYTES = (BLK_W - 2) / BYTE_W;
  localparam int NUM_SIG = 10;

  typedef logic [BLK_W-1:0]  blk_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [3*BYTE_W-1:0] tag_t;   // {M0, M1, M2}

  localparam logic [1:0] SYNC_CTRL = 2'b10;

  // Fixed identifier for sub-lane (sig, sub).
  function automatic tag_t lane_tag(input int sig, input int sub);
    tag_t t;
    case (sig * 2 + sub)
      0:  t = 24'h80B4AF;  1:  t = 24'h29851D;
      2:  t = 24'h112AD8;  3:  t = 24'hBF7E4D;
      4:  t = 24'h7C3F1C;  5:  t = 24'hEE8BBA;
      6:  t = 24'hD18725;  7:  t = 24'hD00239;
      8:  t = 24'h6DFE11;  9:  t = 24'hA1D2AB;
      10: t = 24'h0EC63C;  11: t = 24'h987807;
      12: t = 24'h1BBFA0;  13: t = 24'h3190C3;
      14: t = 24'h0D9A46;  15: t = 24'h9F08B6;
      16: t = 24'hBB559D;  17: t = 24'hA805FC;
      18: t = 24'h04A194;  default: t = 24'h0772DB;
    endcase
    return t;
  endfunction

  // Interleaved parity contribution of one block.
  function automatic byte_t blk_parity(input blk_t b);
    byte_t p;
    p = '0;
    for (int k = 0; k < PAY_BYTES; k++) p ^= b[2 + BYTE_W*k +: BYTE_W];
    p[3] ^= b[0];
    p[4] ^= b[1];
    return p;
  endfunction

  function automatic blk_t build_marker(input tag_t tag, input byte_t bip);
    byte_t m0, m1, m2;
    m0 = tag[23:16];
    m1 = tag[15:8];
    m2 = tag[7:0];
    return {~bip, ~m2, ~m1, ~m0, bip, m2, m1, m0, SYNC_CTRL};
  endfunction
endpackage

// File: rtl/deal_ctrl.sv
module deal_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic mark_now,
  output logic in_ready,
  output logic take_mark,
  output logic [1:0] take_data
);
  logic sel_q, sel_d;
  logic accept;

  always_comb begin
    in_ready  = ~mark_now;
    accept    = in_valid & ~mark_now;
    take_mark = mark_now;
    take_data = 2'b00;
    take_data[sel_q] = accept;
    sel_d = accept ? ~sel_q : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else if (accept) sel_q <= sel_d;
  end

  // R2: at most one sub-lane takes a data block per cycle
  assert_single_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_data));

  // R3: a marker never moves the lane selection
  assert_mark_keeps_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mark_now |=> $stable(sel_q));
endmodule

// File: rtl/split_lane.sv
module split_lane
  import mlg_split_pkg::*;
#(
  parameter int SIG_IDX = 0,
  parameter int SUB_IDX = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take_data,
  input  logic take_mark,
  input  blk_t data_in,
  output blk_t out_blk,
  output logic out_vld
);
  localparam tag_t TAG = lane_tag(SIG_IDX, SUB_IDX);

  byte_t acc_q, acc_d;
  blk_t  blk_d, mark_blk;
  logic  vld_d, blk_en;

  always_comb begin
    mark_blk = build_marker(TAG, acc_q);
    blk_en   = take_data | take_mark;
    vld_d    = blk_en;
    blk_d    = take_mark ? mark_blk : data_in;
    if (take_mark)      acc_d = blk_parity(mark_blk);
    else if (take_data) acc_d = acc_q ^ blk_parity(data_in);
    else                acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      out_vld <= 1'b0;
      out_blk <= '0;
    end else begin
      acc_q   <= acc_d;
      out_vld <= vld_d;
      if (blk_en) out_blk <= blk_d;
    end
  end

  // R10: valid only when this lane was handed something
  assert_lane_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_data || take_mark) |=> !out_vld);

  // R2: a handed data block appears unchanged
  assert_data_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_data && !take_mark) |=> (out_vld && out_blk == $past(data_in)));
endmodule

// File: rtl/mlg_pair_splitter.sv
module mlg_pair_splitter
  import mlg_split_pkg::*;
#(
  parameter int SIG_IDX = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [65:0] in_blk,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        mark_now,
  output logic [65:0] lane0_blk,
  output logic        lane0_vld,
  output logic [65:0] lane1_blk,
  output logic        lane1_vld
);
  logic       take_mark;
  logic [1:0] take_data;
  blk_t [1:0] lane_blk;
  logic [1:0] lane_vld;

  deal_ctrl u_deal (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mark_now  (mark_now),
    .in_ready  (in_ready),
    .take_mark (take_mark),
    .take_data (take_data)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    split_lane #(.SIG_IDX(SIG_IDX), .SUB_IDX(g)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_data (take_data[g]),
      .take_mark (take_mark),
      .data_in   (in_blk),
      .out_blk   (lane_blk[g]),
      .out_vld   (lane_vld[g])
    );
  end

  assign lane0_blk = lane_blk[0];
  assign lane1_blk = lane_blk[1];
  assign lane0_vld = lane_vld[0];
  assign lane1_vld = lane_vld[1];

  // R4: a strobe yields markers with control sync on both lanes
  assert_mark_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mark_now |=> (lane0_vld && lane1_vld &&
                  lane0_blk[1:0] == SYNC_CTRL && lane1_blk[1:0] == SYNC_CTRL));

  // R4: both lanes valid together only after a strobe
  assert_both_only_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mark_now |=> !(lane0_vld && lane1_vld));

  // R2: an accepted block yields exactly one valid lane
  assert_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (lane0_vld ^ lane1_vld));

  // R8: marker inverse parity byte
  assert_inv_parity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mark_now |=> (lane0_blk[65:58] == ~lane0_blk[33:26] &&
                  lane1_blk[65:58] == ~lane1_blk[33:26]));
endmodule

// File: tb/tb_mlg_pair_splitter.sv
module tb_mlg_pair_splitter;
  logic        clk;
  logic        rst_n;
  logic [65:0] in_blk;
  logic        in_valid;
  logic        in_ready;
  logic        mark_now;
  logic [65:0] lane0_blk, lane1_blk;
  logic        lane0_vld, lane1_vld;

  int n_tests;
  int n_fail;
  logic [7:0]  exp_acc [2];
  logic        exp_sel;
  logic [63:0] seed;

  mlg_pair_splitter #(.SIG_IDX(0)) dut (
    .clk(clk), .rst_n(rst_n), .in_blk(in_blk), .in_valid(in_valid),
    .in_ready(in_ready), .mark_now(mark_now),
    .lane0_blk(lane0_blk), .lane0_vld(lane0_vld),
    .lane1_blk(lane1_blk), .lane1_vld(lane1_vld)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] par(input logic [65:0] b);
    logic [7:0] p;
    p = 8'h00;
    for (int j = 2; j < 66; j++) p[(j - 2) % 8] = p[(j - 2) % 8] ^ b[j];
    p[3] = p[3] ^ b[0];
    p[4] = p[4] ^ b[1];
    return p;
  endfunction

  function automatic logic [65:0] mk(input int sub, input logic [7:0] bip);
    logic [7:0] a, b, c;
    if (sub == 0) begin a = 8'h80; b = 8'hB4; c = 8'hAF; end
    else          begin a = 8'h29; b = 8'h85; c = 8'h1D; end
    return {~bip, ~c, ~b, ~a, bip, c, b, a, 2'b10};
  endfunction

  task automatic check(input string req, input logic [65:0] act, input logic [65:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [65:0] next_data();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return {seed[1:0] ^ seed[63:62], seed};
  endfunction

  // Drive one cycle and check the outputs just after the edge.
  task automatic cyc(input logic v, input logic [65:0] d, input logic m);
    logic acc;
    logic [65:0] e0, e1;
    in_valid = v; in_blk = d; mark_now = m;
    #1;
    check(m ? "R4 ready" : "R1 ready", {65'd0, in_ready}, {65'd0, ~m});
    acc = v & ~m;
    @(posedge clk);
    #1;
    if (m) begin
      e0 = mk(0, exp_acc[0]);
      e1 = mk(1, exp_acc[1]);
      check("R4 valid", {64'd0, lane1_vld, lane0_vld}, 66'd3);
      check("R5 R6 R7 R9 lane0 marker", lane0_blk, e0);
      check("R5 R6 R7 R9 lane1 marker", lane1_blk, e1);
      check("R8 lane0 inverse", {58'd0, lane0_blk[65:58]}, {58'd0, ~lane0_blk[33:26]});
      exp_acc[0] = par(e0);
      exp_acc[1] = par(e1);
    end else if (acc) begin
      check("R2 R3 valid", {64'd0, lane1_vld, lane0_vld}, exp_sel ? 66'd2 : 66'd1);
      check("R2 R3 data", exp_sel ? lane1_blk : lane0_blk, d);
      exp_acc[exp_sel] = exp_acc[exp_sel] ^ par(d);
      exp_sel = ~exp_sel;
    end else begin
      check("R10 idle", {64'd0, lane1_vld, lane0_vld}, 66'd0);
    end
  endtask

  initial begin
    #1_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [65:0] d;
    n_tests = 0; n_fail = 0;
    seed = 64'h1234_5678_9ABC_DEF1;
    exp_acc[0] = 8'h00; exp_acc[1] = 8'h00; exp_sel = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; mark_now = 1'b0; in_blk = '0;
    #23;
    check("R1 reset valid", {64'd0, lane1_vld, lane0_vld}, 66'd0);
    check("R1 reset ready", {65'd0, in_ready}, 66'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // first marker right after reset: empty window
    cyc(1'b0, '0, 1'b1);
    // windows of 0..7 blocks, with idle gap patterns
    for (int p = 0; p < 8; p++) begin
      for (int g = 0; g < 3; g++) begin
        for (int k = 0; k < p; k++) begin
          d = next_data();
          if (g != 0 && (k % (g + 1)) == 0) cyc(1'b0, d, 1'b0);
          cyc(1'b1, d, 1'b0);
        end
        d = next_data();
        // strobe while a block is waiting; block must survive (R4)
        cyc(g == 1, d, 1'b1);
        if (g == 1) cyc(1'b1, d, 1'b0);
      end
    end
    // back-to-back markers
    cyc(1'b1, next_data(), 1'b1);
    cyc(1'b0, '0, 1'b1);
    // all-ones and all-zero blocks
    cyc(1'b1, {66{1'b1}}, 1'b0);
    cyc(1'b1, 66'd0, 1'b0);
    cyc(1'b1, 66'h2_AAAA_AAAA_AAAA_AAAA, 1'b0);
    cyc(1'b0, '0, 1'b1);
    // long run
    for (int k = 0; k < 200; k++) cyc(1'b1, next_data(), (k % 37) == 36);
    cyc(1'b0, '0, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule